// File: doc/BRIEF.md
# Programmable Address Region Matcher

The block keeps a set of programmable address regions. Each one has a start address and a 4-bit logarithmic size code. On every clock it compares a 32-bit physical address against all of them and reports which regions contain the address. It also drives one combined non-cacheable flag. The flag folds in two fixed legacy windows, each switched on by its own control bit: the span from 640K to 1M, and the lowest 64K of every megabyte.

Software-style configuration arrives over a byte-wide write port. Each region takes three consecutive byte slots, and one further slot holds the two legacy control bits. Logic downstream consumes the registered match vector and the non-cacheable flag. Whatever cache or bus behaviour uses that flag is outside this block.

Top module: `addr_region_match`

## Requirements
- R1: Region r is configured at write index 3r (start bits 31-24), 3r+1 (start bits 23-16) and 3r+2 (start bits 15-12 in the upper nibble, size code in the lower nibble). Index 3*NREG is the control byte: bit 1 enables the 640K-1M window and bit 0 enables the low-64K-per-megabyte window.
- R2: A region whose size code is 0 never matches, whatever its start bytes hold.
- R3: A size code c from 1 to 14 gives a region of 2^(11+c) bytes, from 4K up to 32M. The region matches when address bits 31 down to 11+c equal the same start bits. Start bits below the region size are ignored.
- R4: Size code 15 makes the region match every 32-bit address.
- R5: With control bit 1 set, addresses 000A0000h to 000FFFFFh are flagged non-cacheable.
- R6: With control bit 0 set, any address whose bits 19-16 are zero is flagged non-cacheable.
- R7: Bit r of hit_vec reports region r. nc_out is the OR of all region matches and both enabled legacy windows.
- R8: The outputs are registered. They reflect the address presented in the previous clock cycle, judged against the configuration held in that cycle.
- R9: Reset clears every region byte and both control bits, and it drives hit_vec and nc_out to zero.
- R10: A write to an index above 3*NREG changes neither the regions nor the control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | IW | Configuration byte index |
| cfg_wdata | input | 8 | Configuration byte data |
| addr_in | input | 32 | Physical address to classify |
| hit_vec | output | NREG | Registered per-region match flags |
| nc_out | output | 1 | Registered combined non-cacheable flag |

## Verification
The legacy-window assertions keep their own shadow of the control byte, built from writes seen at the port. They therefore assume every control write goes through cfg_we with a defined index and data, and that no write lands during reset. The bench meets this by driving every input at the falling edge only, and by issuing each configuration write as a single one-cycle strobe after reset has been released. Addresses are held for a full cycle before sampling, so each registered result corresponds to exactly one presented address.

// File: rtl/addr_region_match.sv
module addr_region_match #(
  parameter int NREG = 8,
  localparam int IW = $clog2(3*NREG+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [7:0]      cfg_wdata,
  input  logic [31:0]     addr_in,
  output logic [NREG-1:0] hit_vec,
  output logic            nc_out
);
  localparam int NBYTE = 3*NREG;
  localparam logic [IW-1:0] CTRL_IDX = IW'(NBYTE);

  logic [7:0] cfg_q [NBYTE];
  logic [1:0] ctrl_q;
  logic [NREG-1:0] hit_d;
  logic win_hi, win_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) cfg_q[i] <= '0;
      ctrl_q <= '0;
    end else if (cfg_we) begin
      if (cfg_idx < CTRL_IDX) cfg_q[cfg_idx] <= cfg_wdata;
      else if (cfg_idx == CTRL_IDX) ctrl_q <= cfg_wdata[1:0];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    logic [31:0] base, keep;
    logic [3:0]  code;
    logic [4:0]  sh;
    assign base = {cfg_q[3*r], cfg_q[3*r+1], cfg_q[3*r+2][7:4], 12'h000};
    assign code = cfg_q[3*r+2][3:0];
    assign sh   = 5'd11 + {1'b0, code};
    assign keep = (code == 4'hF) ? 32'h0 : ~((32'd1 << sh) - 32'd1);
    assign hit_d[r] = (code != 4'h0) && (((addr_in ^ base) & keep) == 32'h0);
  end

  assign win_hi = ctrl_q[1] && (addr_in[31:20] == 12'h000) && (addr_in[19:16] >= 4'hA);
  assign win_lo = ctrl_q[0] && (addr_in[19:16] == 4'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vec <= '0;
      nc_out  <= 1'b0;
    end else begin
      hit_vec <= hit_d;
      nc_out  <= (|hit_d) | win_hi | win_lo;
    end
  end
endmodule

// File: rtl/region_match_chk.sv
module region_match_chk #(
  parameter int NREG = 8,
  localparam int IW = $clog2(3*NREG+1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [IW-1:0]   cfg_idx,
  input logic [7:0]      cfg_wdata,
  input logic [31:0]     addr_in,
  input logic [NREG-1:0] hit_vec,
  input logic            nc_out
);
  logic [1:0] shadow;
  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else if (cfg_we && cfg_idx == IW'(3*NREG)) shadow <= cfg_wdata[1:0];
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (hit_vec == '0 && !nc_out));

  // R7
  hit_implies_nc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> nc_out);

  // R5
  win640_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[1] && addr_in >= 32'h000A0000 && addr_in <= 32'h000FFFFF) |=> nc_out);

  // R6
  low64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[0] && addr_in[19:16] == 4'h0) |=> nc_out);
endmodule

bind addr_region_match region_match_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .addr_in(addr_in), .hit_vec(hit_vec), .nc_out(nc_out));

// File: tb/test_addr_region_match.sv
`timescale 1ns/1ps
module test_addr_region_match;
  localparam int NREG = 8;
  localparam int IW = $clog2(3*NREG+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic [31:0] addr_in = '0;
  logic [NREG-1:0] hit_vec;
  logic nc_out;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  addr_region_match #(.NREG(NREG)) i_addr_region_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .addr_in(addr_in), .hit_vec(hit_vec), .nc_out(nc_out));

  // {address, expected hit_vec, expected nc_out}
  localparam logic [40:0] VEC [16] = '{
    {32'h12345000, 8'h01, 1'b1}, {32'h12345FFF, 8'h01, 1'b1},
    {32'h12346000, 8'h00, 1'b0}, {32'h12344FFF, 8'h00, 1'b0},
    {32'h80000000, 8'h02, 1'b1}, {32'h81FFFFFF, 8'h02, 1'b1},
    {32'h82000000, 8'h00, 1'b0}, {32'h7FFFFFFF, 8'h00, 1'b0},
    {32'h00030000, 8'h08, 1'b1}, {32'h0003FFFF, 8'h08, 1'b1},
    {32'h00040000, 8'h00, 1'b0}, {32'h000A0000, 8'h00, 1'b1},
    {32'h000FFFFF, 8'h00, 1'b1}, {32'h0009FFFF, 8'h00, 1'b0},
    {32'h00100000, 8'h00, 1'b0}, {32'h00200000, 8'h00, 1'b0}
  };

  task automatic check(string req, logic [NREG-1:0] eh, logic en);
    checks++;
    if (hit_vec !== eh || nc_out !== en) begin
      failures++;
      $display("FAIL %s addr=%h hit=%h nc=%b expected hit=%h nc=%b",
               req, addr_in, hit_vec, nc_out, eh, en);
    end
  endtask

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(logic [31:0] a);
    @(negedge clk) addr_in = a;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    addr_in = 32'h12345000;
    repeat (3) @(negedge clk);
    check("R9 reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    probe(32'h000A0000);
    check("R9 cleared", 8'h00, 1'b0);

    // R1 R3 configuration
    wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'h51);
    wr(3, 8'h80); wr(4, 8'h37); wr(5, 8'hAE);
    wr(6, 8'h12); wr(7, 8'h34); wr(8, 8'h50);
    wr(9, 8'h00); wr(10, 8'h03); wr(11, 8'h75);
    wr(24, 8'h02);
    for (int i = 0; i < 16; i++) begin
      probe(VEC[i][40:9]);
      check("R1 R2 R3 R5 R7 table", VEC[i][8:1], VEC[i][0]);
    end

    // R6 low 64K window, R5 window off
    wr(24, 8'h01);
    probe(32'h00100000); check("R6 low64 start", 8'h00, 1'b1);
    probe(32'h0010FFFF); check("R6 low64 end", 8'h00, 1'b1);
    probe(32'h00110000); check("R6 outside", 8'h00, 1'b0);
    probe(32'h000A0000); check("R5 disabled", 8'h00, 1'b0);

    // R10 out-of-range index ignored
    wr(25, 8'hFF); wr(31, 8'hFF);
    probe(32'h000A0000); check("R10 ctrl unchanged", 8'h00, 1'b0);
    probe(32'h55555555); check("R10 regions unchanged", 8'h00, 1'b0);

    // R4 whole-space region
    wr(21, 8'h00); wr(22, 8'h00); wr(23, 8'h0F);
    probe(32'h55555555); check("R4 4G", 8'h80, 1'b1);
    probe(32'h12345000); check("R4 R7 multi", 8'h81, 1'b1);

    // R8 one-cycle latency
    wr(23, 8'h00);
    probe(32'h00040000); check("R8 before", 8'h00, 1'b0);
    @(negedge clk) addr_in = 32'h12345000;
    #1 check("R8 not yet", 8'h00, 1'b0);
    @(negedge clk); check("R8 after edge", 8'h01, 1'b1);

    // R9 reset mid-run
    rst_n = 1'b0;
    @(negedge clk); check("R9 reset outputs", 8'h00, 1'b0);
    rst_n = 1'b1;
    probe(32'h12345000); check("R9 regions cleared", 8'h00, 1'b0);
    probe(32'h00100000); check("R9 ctrl cleared", 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule